// File: doc/BRIEF.md
# Switching-Period Hysteretic Enable Qualifier

This block decides whether a downstream synchronous-rectifier controller should be kept running or put to sleep. It watches a one-cycle power-cycle strobe, measures the number of clock cycles between successive strobes, and sorts each measured period against two programmable limits. The first is a long "off" limit and the second is a shorter "on" limit. The gap between the two limits gives hysteresis between the two states.

While the rectifier is enabled, the block counts long periods that follow one another without a break. Once 63 such periods have been seen in a row, it asserts its active-low disable output. While the rectifier is disabled, it counts short periods. These do not need to be consecutive, and the count does not restart when a long period appears. After 32 short periods, it releases the output again. A wake-event flag from the droop monitor is accepted but has no influence on either count or on the output. The debug outputs show the two running counts.

There is no data stream here. The strobe, wake flag, limits and outputs are plain control and status pins with no handshake and no back-pressure.

Top module: `sp_enable_qualifier`

## Requirements
- R1: After reset, `rect_dis_n` is 1 (rectifier enabled), and `dbg_run` and `dbg_acc` are 0.
- R2: The first strobe after reset only starts timing. It changes neither count nor the output.
- R3: A period is the number of clock cycles from one sampled strobe to the next. It saturates at 2^PW-1, so a very long gap still counts as longer than any limit below all-ones.
- R4: While enabled, a period greater than `lim_off` increments `dbg_run`. The 63rd consecutive one drives `rect_dis_n` to 0 and clears `dbg_run`.
- R5: While enabled, a period less than `lim_off` clears `dbg_run`.
- R6: While disabled, a period less than `lim_on` increments `dbg_acc`. The 32nd one drives `rect_dis_n` to 1 and clears `dbg_acc`.
- R7: While disabled, a period at or above `lim_on` leaves `dbg_acc` unchanged. Short periods therefore accumulate across long ones, and release can come on the very next short period.
- R8: A period exactly equal to the limit that applies in the current state leaves both counts and the output unchanged.
- R9: `wake_evt` has no effect on either count or on `rect_dis_n`.
- R10: The updated output and counts are visible two clock edges after the edge that samples the strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pcd_strobe | input | 1 | One-cycle power-cycle strobe |
| wake_evt | input | 1 | Wake-event flag (ignored by the qualifier) |
| lim_off | input | PW | Long-period limit used while enabled |
| lim_on | input | PW | Short-period limit used while disabled |
| rect_dis_n | output | 1 | 0 = rectifier disabled, 1 = rectifier enabled |
| dbg_run | output | clog2(N_OFF+1) | Consecutive long-period count |
| dbg_acc | output | clog2(N_ON+1) | Cumulative short-period count |

## Verification
The bench runs a reduced 8-bit period configuration and predicts every count arithmetically after each strobe. The first corner case is a gap of several hundred cycles, which the timer must saturate. A timer that wrapped would see a short period and clear the run count. The second corner is a set of periods exactly on each limit: a design that used inclusive compares would count them or clear on them. The bench also interleaves short and long periods while disabled. A design that restarted the cumulative count on long periods would never release within the expected strobe. Wake pulses are placed inside the gaps, and a design that let them touch state would show shifted counts.

// File: rtl/sp_qual_pkg.sv
package sp_qual_pkg;

  // Verdict on one measured period
  typedef struct packed {
    logic longer_off;   // period > lim_off
    logic shorter_off;  // period < lim_off
    logic shorter_on;   // period < lim_on
  } sp_cls_t;

  typedef enum logic {
    ST_ON  = 1'b0,  // rectifier enabled, output released
    ST_OFF = 1'b1   // rectifier disabled, output driven low
  } sp_state_t;

endpackage

// File: rtl/sp_period_timer.sv
module sp_period_timer #(
  parameter int PW = 20
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          strobe,
  output logic          iv_vld,
  output logic [PW-1:0] iv_len
);

  localparam logic [PW-1:0] SAT = {PW{1'b1}};
  localparam logic [PW-1:0] ONE = PW'(1);

  logic [PW-1:0] cnt_q;
  logic          armed_q;

  // cnt_q holds the distance in cycles since the last sampled strobe
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      armed_q <= 1'b0;
      iv_vld  <= 1'b0;
      iv_len  <= '0;
    end else begin
      iv_vld <= strobe && armed_q;
      if (strobe) begin
        if (armed_q) iv_len <= cnt_q;
        armed_q <= 1'b1;
        cnt_q   <= ONE;
      end else if (cnt_q != SAT) begin
        cnt_q <= cnt_q + ONE;
      end
    end
  end

  p_sat_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == SAT && !strobe) |=> cnt_q == SAT);

  p_first_ignored_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!armed_q && strobe) |=> !iv_vld);

  p_restart_r3: assert property (@(posedge clk) disable iff (!rst_n)
    strobe |=> cnt_q == ONE);

endmodule

// File: rtl/sp_interval_class.sv
module sp_interval_class
  import sp_qual_pkg::*;
#(
  parameter int PW = 20
) (
  input  logic [PW-1:0] iv_len,
  input  logic [PW-1:0] lim_off,
  input  logic [PW-1:0] lim_on,
  output sp_cls_t       cls
);

  // Strict compares: a period equal to a limit is neither longer nor shorter
  always_comb begin
    cls.longer_off  = iv_len > lim_off;
    cls.shorter_off = iv_len < lim_off;
    cls.shorter_on  = iv_len < lim_on;
  end

endmodule

// File: rtl/sp_hyst_ctrl.sv
module sp_hyst_ctrl
  import sp_qual_pkg::*;
#(
  parameter int N_OFF = 63,
  parameter int N_ON  = 32,
  parameter int RW    = 6,
  parameter int AW    = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          iv_vld,
  input  sp_cls_t       cls,
  input  logic          wake_evt,
  output logic          rect_dis_n,
  output logic [RW-1:0] run_cnt,
  output logic [AW-1:0] acc_cnt
);

  localparam logic [RW-1:0] RUN_LAST = RW'(N_OFF - 1);
  localparam logic [AW-1:0] ACC_LAST = AW'(N_ON - 1);

  sp_state_t     st_q, st_d;
  logic [RW-1:0] run_q, run_d;
  logic [AW-1:0] acc_q, acc_d;

  always_comb begin
    st_d  = st_q;
    run_d = run_q;
    acc_d = acc_q;
    if (iv_vld) begin
      case (st_q)
        ST_ON: begin
          if (cls.longer_off) begin
            if (run_q == RUN_LAST) begin
              run_d = '0;
              st_d  = ST_OFF;
            end else begin
              run_d = run_q + RW'(1);
            end
          end else if (cls.shorter_off) begin
            run_d = '0;
          end
        end
        ST_OFF: begin
          if (cls.shorter_on) begin
            if (acc_q == ACC_LAST) begin
              acc_d = '0;
              st_d  = ST_ON;
            end else begin
              acc_d = acc_q + AW'(1);
            end
          end
        end
        default: st_d = ST_ON;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_ON;
      run_q <= '0;
      acc_q <= '0;
    end else begin
      st_q  <= st_d;
      run_q <= run_d;
      acc_q <= acc_d;
    end
  end

  assign rect_dis_n = (st_q == ST_ON);
  assign run_cnt    = run_q;
  assign acc_cnt    = acc_q;

  p_enter_after_run_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rect_dis_n) |-> ($past(run_q) == RUN_LAST && run_q == '0));

  p_release_after_acc_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rect_dis_n) |-> ($past(acc_q) == ACC_LAST && acc_q == '0));

  p_run_idle_when_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_OFF) |-> run_q == '0);

  p_acc_idle_when_on_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_ON) |-> acc_q == '0);

  p_short_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (iv_vld && st_q == ST_ON && cls.shorter_off) |=> run_q == '0);

  p_acc_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (iv_vld && st_q == ST_OFF && !cls.shorter_on) |=> $stable(acc_q));

  p_wake_no_effect_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wake_evt && !iv_vld) |=> ($stable(run_q) && $stable(acc_q) && $stable(st_q)));

endmodule

// File: rtl/sp_enable_qualifier.sv
module sp_enable_qualifier
  import sp_qual_pkg::*;
#(
  parameter int PW    = 20,
  parameter int N_OFF = 63,
  parameter int N_ON  = 32,
  localparam int RW   = $clog2(N_OFF + 1),
  localparam int AW   = $clog2(N_ON + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pcd_strobe,
  input  logic          wake_evt,
  input  logic [PW-1:0] lim_off,
  input  logic [PW-1:0] lim_on,
  output logic          rect_dis_n,
  output logic [RW-1:0] dbg_run,
  output logic [AW-1:0] dbg_acc
);

  logic          iv_vld;
  logic [PW-1:0] iv_len;
  sp_cls_t       cls;

  sp_period_timer #(.PW(PW)) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .strobe (pcd_strobe),
    .iv_vld (iv_vld),
    .iv_len (iv_len)
  );

  sp_interval_class #(.PW(PW)) u_class (
    .iv_len  (iv_len),
    .lim_off (lim_off),
    .lim_on  (lim_on),
    .cls     (cls)
  );

  sp_hyst_ctrl #(
    .N_OFF (N_OFF),
    .N_ON  (N_ON),
    .RW    (RW),
    .AW    (AW)
  ) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .iv_vld     (iv_vld),
    .cls        (cls),
    .wake_evt   (wake_evt),
    .rect_dis_n (rect_dis_n),
    .run_cnt    (dbg_run),
    .acc_cnt    (dbg_acc)
  );

  p_reset_released_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> rect_dis_n);

endmodule

// File: tb/sp_enable_qualifier_tb.sv
module sp_enable_qualifier_tb;

  localparam int PW    = 8;
  localparam int N_OFF = 63;
  localparam int N_ON  = 32;
  localparam int RW    = $clog2(N_OFF + 1);
  localparam int AW    = $clog2(N_ON + 1);
  localparam int LOFF  = 40;
  localparam int LON   = 20;
  localparam int SATV  = (1 << PW) - 1;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          pcd_strobe = 1'b0;
  logic          wake_evt = 1'b0;
  logic [PW-1:0] lim_off = PW'(LOFF);
  logic [PW-1:0] lim_on  = PW'(LON);
  logic          rect_dis_n;
  logic [RW-1:0] dbg_run;
  logic [AW-1:0] dbg_acc;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  // reference model state
  bit m_armed = 0;
  bit m_off   = 0;
  int m_run   = 0;
  int m_acc   = 0;

  always #2 clk = ~clk;  // 250 MHz

  sp_enable_qualifier #(.PW(PW), .N_OFF(N_OFF), .N_ON(N_ON)) u_dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .pcd_strobe (pcd_strobe),
    .wake_evt   (wake_evt),
    .lim_off    (lim_off),
    .lim_on     (lim_on),
    .rect_dis_n (rect_dis_n),
    .dbg_run    (dbg_run),
    .dbg_acc    (dbg_acc)
  );

  task automatic check(string tag);
    total++;
    if (rect_dis_n !== !m_off || int'(dbg_run) != m_run || int'(dbg_acc) != m_acc) begin
      bad++;
      $display("FAIL %s: got dis_n=%0b run=%0d acc=%0d, exp dis_n=%0b run=%0d acc=%0d",
               tag, rect_dis_n, dbg_run, dbg_acc, !m_off, m_run, m_acc);
    end
  endtask

  // One strobe n cycles after the previous one (n >= 4); checks two edges after sampling (R10)
  task automatic send(int n, bit wk, string tag);
    for (int i = 0; i < n - 2; i++) begin
      @(negedge clk);
      wake_evt = wk && (i == 0);
    end
    wake_evt   = 1'b0;
    pcd_strobe = 1'b1;
    @(negedge clk);
    pcd_strobe = 1'b0;
    @(negedge clk);
    if (!m_armed) begin
      m_armed = 1;
    end else begin
      int len = (n > SATV) ? SATV : n;
      if (!m_off) begin
        if (len > LOFF) begin
          if (m_run == N_OFF - 1) begin m_run = 0; m_off = 1; end
          else m_run++;
        end else if (len < LOFF) m_run = 0;
      end else if (len < LON) begin
        if (m_acc == N_ON - 1) begin m_acc = 0; m_off = 0; end
        else m_acc++;
      end
    end
    check(tag);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset state");
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after release");

    send(50, 0, "R2 first strobe ignored");
    for (int i = 0; i < 10; i++) send(50, 0, "R4 long counts");
    send(LOFF, 0, "R8 equal to off limit");
    send(30, 0, "R5 short clears run");
    send(LON, 0, "R5 short vs on limit clears run");
    send(600, 0, "R3 saturated gap counts long");
    for (int i = 0; i < 61; i++) send(50, (i % 7) == 0, "R9 R4 long run with wake");
    send(50, 0, "R4 63rd long disables");
    send(50, 0, "R7 long while off");
    send(30, 0, "R7 mid while off");
    send(LON, 0, "R8 equal to on limit");
    for (int i = 0; i < 31; i++) begin
      send(8, 0, "R6 short accumulates");
      send(50, 1, "R7 long keeps acc");
    end
    send(700, 1, "R7 saturated gap keeps acc");
    send(8, 0, "R7 R6 release on next short");
    send(8, 0, "R5 short while on");
    for (int i = 0; i < 63; i++) send(45, 0, "R4 second run");
    for (int i = 0; i < 32; i++) send(6, i == 5, "R6 consecutive shorts release");
    send(50, 0, "R4 counting resumes");
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: got no completion, exp completion");
      end
    join_any
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule